// File: doc/BRIEF.md
# Flash Sector Erase Sequencer

This block erases a single sector of a byte-wide parallel NOR flash on behalf of a host. The host raises `req_start` for one clock with any address inside the sector it wants cleared. The sequencer then writes the six-cycle erase command on the flash pins. After that it reads the same sector address repeatedly and watches bit 7 of the returned byte. While the erase runs, that bit reads 0; it reads 1 once the erase has finished. The low seven bits can settle later than bit 7, so the sequencer does one more read after bit 7 goes high and accepts the sector as erased only if that read returns FFh. It reports the result with a one-clock `done` or `err` pulse.

Every flash access passes through one bus-cycle engine, with phases `PH_IDLE`, `PH_SETUP`, `PH_STROBE` and `PH_HOLD`:
- In `PH_SETUP`, chip enable drops and the address and data are already valid.
- In `PH_STROBE`, write enable or output enable is held low for `STROBE_CYC` clocks.
- In `PH_HOLD`, the strobe rises while the address and data stay put, and the cycle completes.

The sequencer state machine runs on top of this engine:
- `SQ_IDLE` goes to `SQ_CMD_GO` on a request.
- `SQ_CMD_GO` goes to `SQ_CMD_WAIT`. `SQ_CMD_WAIT` returns to `SQ_CMD_GO` for the next command step, or goes to `SQ_POLL_GO` after the sixth write.
- `SQ_POLL_GO` goes to `SQ_POLL_WAIT`. `SQ_POLL_WAIT` returns to `SQ_POLL_GO` while bit 7 is 0. It goes to `SQ_CONF_GO` when bit 7 is 1, and to `SQ_FAIL` when the poll budget runs out.
- `SQ_CONF_GO` goes to `SQ_CONF_WAIT`. `SQ_CONF_WAIT` goes to `SQ_DONE` when the confirming read returns FFh, and to `SQ_FAIL` otherwise.
- `SQ_DONE` and `SQ_FAIL` each last one clock and return to `SQ_IDLE`.

Top module: `sector_erase_seq`

## Requirements
- R1: While reset is held and after its release with no request, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1, `fl_dout_en` is 0, and `done` and `err` are 0.
- R2: A request produces exactly six write cycles, in this order of (address, data): (UNLOCK_A, AAh), (UNLOCK_B, 55h), (UNLOCK_A, 80h), (UNLOCK_A, AAh), (UNLOCK_B, 55h), (requested sector address, 30h). `fl_dout_en` is 1 whenever `fl_we_n` is 0.
- R3: In every bus cycle the active strobe (`fl_we_n` for writes, `fl_oe_n` for reads) stays low for exactly `STROBE_CYC` clocks. Address and write data do not change while `fl_we_n` is low. `fl_we_n` and `fl_oe_n` are never low together, and neither is low while `fl_ce_n` is 1.
- R4: No read (`fl_oe_n` low) happens before the sixth write's `fl_we_n` has risen. Every read uses the requested sector address.
- R5: A read whose bit 7 is 0 is followed by another read at the same address, unless the poll limit of R8 is reached.
- R6: A read whose bit 7 is 1 is followed by exactly one confirming read. If that read returns FFh, `done` is 1 for exactly one clock and the bus returns to idle.
- R7: If the confirming read returns any value other than FFh, `err` is 1 for exactly one clock, `done` stays 0, and no further bus cycle follows.
- R8: If `MAX_POLLS` consecutive reads all return bit 7 = 0, `err` pulses for one clock right after the last of them, and no further read is made.
- R9: `req_start` is ignored while an erase is in progress. The command writes and the reads keep the sector address latched at acceptance, and only one result pulse is produced.
- R10: A new request presented after a `done` or `err` pulse starts a complete new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_start | input | 1 | One-clock erase request, taken only when idle |
| req_sector | input | ADDR_W | Any address inside the sector to erase |
| done | output | 1 | One-clock pulse: the sector is confirmed erased |
| err | output | 1 | One-clock pulse: poll limit reached or confirming read was not FFh |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | ADDR_W | Flash address |
| fl_dout | output | 8 | Byte driven toward the flash |
| fl_dout_en | output | 1 | Drive enable for `fl_dout` (write cycles only) |
| fl_din | input | 8 | Byte returned by the flash |

## Verification
The bound checker runs on every cycle and enforces the pin-level rules:
- write enable and output enable are never low together, and neither is low while chip enable is high;
- each write-enable pulse is exactly `STROBE_CYC` clocks wide, with address and data held steady;
- the data drive is enabled during writes;
- every read targets the sector latched at acceptance;
- `done` and `err` are single, mutually exclusive pulses.

Other properties depend on how the flash answers, so only the bench's flash model can show them:
- the order of the six command writes;
- that polling continues through a run of zero status bits;
- that a single extra read follows the status flip and is judged against FFh;
- that the poll budget ends the erase with an error and no further reads.

// File: rtl/ers_pkg.sv
package ers_pkg;

    localparam int BYTE_W  = 8;
    localparam int CMD_LEN = 6;
    localparam int STEP_W  = $clog2(CMD_LEN);
    localparam int STAT_BIT = 7;

    localparam logic [BYTE_W-1:0] CODE_KEY1   = 8'hAA;
    localparam logic [BYTE_W-1:0] CODE_KEY2   = 8'h55;
    localparam logic [BYTE_W-1:0] CODE_ARM    = 8'h80;
    localparam logic [BYTE_W-1:0] CODE_SECTOR = 8'h30;
    localparam logic [BYTE_W-1:0] BLANK_BYTE  = 8'hFF;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_t;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_CMD_GO,
        SQ_CMD_WAIT,
        SQ_POLL_GO,
        SQ_POLL_WAIT,
        SQ_CONF_GO,
        SQ_CONF_WAIT,
        SQ_DONE,
        SQ_FAIL
    } seq_t;

endpackage

// File: rtl/fbus_cycle.sv
module fbus_cycle
    import ers_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int STROBE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_wr,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [BYTE_W-1:0] go_data,
    output logic              cyc_done,
    output logic [BYTE_W-1:0] rd_data,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [BYTE_W-1:0] fl_dout,
    output logic              fl_dout_en,
    input  logic [BYTE_W-1:0] fl_din
);

    localparam int CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(STROBE_CYC - 1);

    phase_t            ph_q, ph_d;
    logic [CW-1:0]     cnt_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;

    // next phase
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:   if (go) ph_d = PH_SETUP;
            PH_SETUP:  ph_d = PH_STROBE;
            PH_STROBE: if (cnt_q == LAST_CNT) ph_d = PH_HOLD;
            PH_HOLD:   ph_d = PH_IDLE;
            default:   ph_d = PH_IDLE;
        endcase
    end

    // state register and cycle latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            rd_data <= '0;
        end else begin
            ph_q <= ph_d;
            if (ph_q == PH_IDLE && go) begin
                wr_q   <= go_wr;
                addr_q <= go_addr;
                data_q <= go_data;
            end
            if (ph_q == PH_STROBE) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST_CNT && !wr_q) rd_data <= fl_din;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // pin decode
    always_comb begin
        fl_ce_n    = (ph_q == PH_IDLE);
        fl_we_n    = !((ph_q == PH_STROBE) && wr_q);
        fl_oe_n    = !((ph_q == PH_STROBE) && !wr_q);
        fl_addr    = addr_q;
        fl_dout    = data_q;
        fl_dout_en = wr_q && (ph_q != PH_IDLE);
        cyc_done   = (ph_q == PH_HOLD);
    end

endmodule

// File: rtl/erase_cmd_rom.sv
module erase_cmd_rom
    import ers_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter logic [ADDR_W-1:0] UNLOCK_A = ADDR_W'('h5555),
    parameter logic [ADDR_W-1:0] UNLOCK_B = ADDR_W'('h2AAA)
) (
    input  logic [STEP_W-1:0] step,
    input  logic [ADDR_W-1:0] sector,
    output logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] data,
    output logic              last
);

    always_comb begin
        last = (step == STEP_W'(CMD_LEN - 1));
        unique case (step)
            STEP_W'(0): begin addr = UNLOCK_A; data = CODE_KEY1;   end
            STEP_W'(1): begin addr = UNLOCK_B; data = CODE_KEY2;   end
            STEP_W'(2): begin addr = UNLOCK_A; data = CODE_ARM;    end
            STEP_W'(3): begin addr = UNLOCK_A; data = CODE_KEY1;   end
            STEP_W'(4): begin addr = UNLOCK_B; data = CODE_KEY2;   end
            STEP_W'(5): begin addr = sector;   data = CODE_SECTOR; end
            default:    begin addr = '0;       data = '0;          end
        endcase
    end

endmodule

// File: rtl/poll_limit.sv
module poll_limit #(
    parameter int MAX_POLLS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic last
);

    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr)   cnt_q <= '0;
        else if (bump)  cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == PW'(MAX_POLLS - 1));

endmodule

// File: rtl/sector_erase_seq.sv
module sector_erase_seq
    import ers_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int STROBE_CYC = 3,
    parameter int MAX_POLLS  = 100000,
    parameter logic [ADDR_W-1:0] UNLOCK_A = ADDR_W'('h5555),
    parameter logic [ADDR_W-1:0] UNLOCK_B = ADDR_W'('h2AAA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_sector,
    output logic              done,
    output logic              err,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_dout,
    output logic              fl_dout_en,
    input  logic [7:0]        fl_din
);

    seq_t              st_q, st_d;
    logic [STEP_W-1:0] step_q;
    logic [ADDR_W-1:0] sector_q;

    logic              bus_go, bus_wr, cyc_done;
    logic [ADDR_W-1:0] bus_addr;
    logic [BYTE_W-1:0] rd_data;
    logic [ADDR_W-1:0] cmd_addr;
    logic [BYTE_W-1:0] cmd_data;
    logic              cmd_last;
    logic              lim_clr, lim_bump, lim_last;
    logic              stat_hi;

    assign stat_hi = rd_data[STAT_BIT];

    erase_cmd_rom #(
        .ADDR_W  (ADDR_W),
        .UNLOCK_A(UNLOCK_A),
        .UNLOCK_B(UNLOCK_B)
    ) u_cmd (
        .step  (step_q),
        .sector(sector_q),
        .addr  (cmd_addr),
        .data  (cmd_data),
        .last  (cmd_last)
    );

    poll_limit #(
        .MAX_POLLS(MAX_POLLS)
    ) u_lim (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (lim_clr),
        .bump (lim_bump),
        .last (lim_last)
    );

    fbus_cycle #(
        .ADDR_W    (ADDR_W),
        .STROBE_CYC(STROBE_CYC)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (bus_go),
        .go_wr     (bus_wr),
        .go_addr   (bus_addr),
        .go_data   (cmd_data),
        .cyc_done  (cyc_done),
        .rd_data   (rd_data),
        .fl_ce_n   (fl_ce_n),
        .fl_we_n   (fl_we_n),
        .fl_oe_n   (fl_oe_n),
        .fl_addr   (fl_addr),
        .fl_dout   (fl_dout),
        .fl_dout_en(fl_dout_en),
        .fl_din    (fl_din)
    );

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE:      if (req_start) st_d = SQ_CMD_GO;
            SQ_CMD_GO:    st_d = SQ_CMD_WAIT;
            SQ_CMD_WAIT:  if (cyc_done) st_d = cmd_last ? SQ_POLL_GO : SQ_CMD_GO;
            SQ_POLL_GO:   st_d = SQ_POLL_WAIT;
            SQ_POLL_WAIT: begin
                if (cyc_done) begin
                    if (stat_hi)       st_d = SQ_CONF_GO;
                    else if (lim_last) st_d = SQ_FAIL;
                    else               st_d = SQ_POLL_GO;
                end
            end
            SQ_CONF_GO:   st_d = SQ_CONF_WAIT;
            SQ_CONF_WAIT: if (cyc_done) st_d = (rd_data == BLANK_BYTE) ? SQ_DONE : SQ_FAIL;
            SQ_DONE:      st_d = SQ_IDLE;
            SQ_FAIL:      st_d = SQ_IDLE;
            default:      st_d = SQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= SQ_IDLE;
            step_q   <= '0;
            sector_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == SQ_IDLE && req_start) begin
                sector_q <= req_sector;
                step_q   <= '0;
            end else if (st_q == SQ_CMD_WAIT && cyc_done && !cmd_last) begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        bus_go   = 1'b0;
        bus_wr   = 1'b0;
        bus_addr = sector_q;
        lim_clr  = 1'b0;
        lim_bump = 1'b0;
        done     = 1'b0;
        err      = 1'b0;
        unique case (st_q)
            SQ_IDLE:      lim_clr = 1'b1;
            SQ_CMD_GO: begin
                bus_go   = 1'b1;
                bus_wr   = 1'b1;
                bus_addr = cmd_addr;
            end
            SQ_POLL_GO:   bus_go = 1'b1;
            SQ_POLL_WAIT: lim_bump = cyc_done && !stat_hi;
            SQ_CONF_GO:   bus_go = 1'b1;
            SQ_DONE:      done = 1'b1;
            SQ_FAIL:      err = 1'b1;
            default:      ;
        endcase
    end

endmodule

// File: rtl/sector_erase_chk.sv
module sector_erase_chk #(
    parameter int ADDR_W     = 19,
    parameter int STROBE_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_start,
    input logic [ADDR_W-1:0] req_sector,
    input logic              done,
    input logic              err,
    input logic              fl_ce_n,
    input logic              fl_we_n,
    input logic              fl_oe_n,
    input logic [ADDR_W-1:0] fl_addr,
    input logic [7:0]        fl_dout,
    input logic              fl_dout_en
);

    int unsigned       we_run;
    logic              c_busy;
    logic [ADDR_W-1:0] c_sect;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_run <= 0;
            c_busy <= 1'b0;
            c_sect <= '0;
        end else begin
            we_run <= fl_we_n ? 0 : we_run + 1;
            if (done || err) begin
                c_busy <= 1'b0;
            end else if (!c_busy && req_start) begin
                c_busy <= 1'b1;
                c_sect <= req_sector;
            end
        end
    end

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));

    // R3
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_ce_n |-> (fl_we_n && fl_oe_n));

    // R3
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_we_n && $past(!fl_we_n)) |-> (we_run == STROBE_CYC));

    // R3
    wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));

    // R2
    drive_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> fl_dout_en);

    // R4
    poll_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (c_busy && fl_addr == c_sect));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R7
    result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

endmodule

bind sector_erase_seq sector_erase_chk #(
    .ADDR_W    (ADDR_W),
    .STROBE_CYC(STROBE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .req_sector(req_sector),
    .done      (done),
    .err       (err),
    .fl_ce_n   (fl_ce_n),
    .fl_we_n   (fl_we_n),
    .fl_oe_n   (fl_oe_n),
    .fl_addr   (fl_addr),
    .fl_dout   (fl_dout),
    .fl_dout_en(fl_dout_en)
);

// File: tb/sector_erase_seq_bench.sv
`timescale 1ns/100ps
module sector_erase_seq_bench;

    localparam int AW   = 19;
    localparam int SC   = 2;
    localparam int MAXP = 8;
    localparam logic [AW-1:0] UA = AW'('h5555);
    localparam logic [AW-1:0] UB = AW'('h2AAA);
    localparam int RES_DONE = 1;
    localparam int RES_ERR  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic [AW-1:0] req_sector = '0;
    logic          done, err, fl_ce_n, fl_we_n, fl_oe_n, fl_dout_en;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dout;
    logic [7:0]    fl_din = 8'h00;

    always #2.5 clk = ~clk;

    sector_erase_seq #(
        .ADDR_W(AW), .STROBE_CYC(SC), .MAX_POLLS(MAXP),
        .UNLOCK_A(UA), .UNLOCK_B(UB)
    ) u_sector_erase_seq (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_sector(req_sector),
        .done(done), .err(err), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
        .fl_oe_n(fl_oe_n), .fl_addr(fl_addr), .fl_dout(fl_dout),
        .fl_dout_en(fl_dout_en), .fl_din(fl_din)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    typedef struct packed {
        logic [AW-1:0] a;
        logic [7:0]    d;
    } wr_t;

    wr_t exp_wr[$];
    int  exp_res[$];

    // flash model configuration and state
    int            cfg_busy = 0;
    logic [7:0]    cfg_final = 8'hFF;
    int            reads = 0;
    int            res_seen = 0;
    int            wr_cnt = 0;
    int            erase_left = 0;
    bit            armed = 0;
    bit            trans = 0;
    logic [AW-1:0] cur_sect = '0;
    logic          prev_we = 1'b1;
    logic          prev_oe = 1'b1;
    int            we_len = 0;
    logic [AW-1:0] wa_hold = '0;
    logic [7:0]    wd_hold = '0;

    // monitor and flash model
    always @(negedge clk) begin
        if (rst_n) begin
            if (!fl_we_n) begin
                if (we_len > 0)
                    chk(fl_addr == wa_hold && fl_dout == wd_hold, "R3 addr/data stable",
                        {fl_addr, fl_dout}, {wa_hold, wd_hold});
                chk(fl_dout_en, "R2 drive enable", fl_dout_en, 1);
                we_len++;
                wa_hold = fl_addr;
                wd_hold = fl_dout;
            end
            if (!prev_we && fl_we_n) begin
                chk(we_len == SC, "R3 we width", we_len, SC);
                we_len = 0;
                if (exp_wr.size() == 0) begin
                    chk(0, "R2 unexpected write", {wa_hold, wd_hold}, 0);
                end else begin
                    wr_t e;
                    e = exp_wr.pop_front();
                    chk(wa_hold == e.a && wd_hold == e.d, "R2 write order",
                        {wa_hold, wd_hold}, {e.a, e.d});
                end
                wr_cnt++;
                if (wr_cnt == 6) begin
                    armed = 1;
                    erase_left = cfg_busy;
                    trans = 1;
                    cur_sect = wa_hold;
                end
            end
            if (prev_oe && !fl_oe_n) begin
                reads++;
                chk(armed, "R4 read before command end", armed, 1);
                chk(fl_addr == cur_sect, "R4 poll address", fl_addr, cur_sect);
                if (erase_left > 0) begin
                    fl_din = 8'h3C;
                    erase_left--;
                end else if (trans) begin
                    fl_din = 8'hA5;
                    trans = 0;
                end else begin
                    fl_din = cfg_final;
                end
            end
            if (done || err) begin
                res_seen++;
                armed = 0;
                wr_cnt = 0;
                if (exp_res.size() == 0) begin
                    chk(0, "R9 unexpected result", {done, err}, 0);
                end else begin
                    int r;
                    r = exp_res.pop_front();
                    chk((r == RES_DONE) ? (done && !err) : (err && !done),
                        (r == RES_DONE) ? "R6 done pulse" : "R7/R8 err pulse",
                        {done, err}, (r == RES_DONE) ? 2 : 1);
                end
            end
            prev_we = fl_we_n;
            prev_oe = fl_oe_n;
        end
    end

    // driver: pushes expected items, starts the erase, waits for the result
    task automatic run_erase(input logic [AW-1:0] sect, input int bp, input logic [7:0] fin,
                             input int res, input int exp_reads, input bit poke, input string tag);
        int r0, s0, w;
        cfg_busy  = bp;
        cfg_final = fin;
        exp_wr.push_back({UA, 8'hAA});
        exp_wr.push_back({UB, 8'h55});
        exp_wr.push_back({UA, 8'h80});
        exp_wr.push_back({UA, 8'hAA});
        exp_wr.push_back({UB, 8'h55});
        exp_wr.push_back({sect, 8'h30});
        exp_res.push_back(res);
        r0 = reads;
        s0 = res_seen;
        @(negedge clk);
        req_start  = 1'b1;
        req_sector = sect;
        @(negedge clk);
        req_start  = 1'b0;
        if (poke) begin
            repeat (15) @(negedge clk);
            req_start  = 1'b1;
            req_sector = sect ^ AW'('h40000);
            @(negedge clk);
            req_start  = 1'b0;
        end
        w = 0;
        while (res_seen == s0 && w < 2000) begin
            @(posedge clk);
            w++;
        end
        chk(res_seen == s0 + 1, {tag, " result seen"}, res_seen - s0, 1);
        chk(exp_wr.size() == 0, "R2 six writes issued", exp_wr.size(), 0);
        chk(reads - r0 == exp_reads, {tag, " read count"}, reads - r0, exp_reads);
        repeat (12) @(posedge clk);
        chk(reads - r0 == exp_reads, {tag, " no reads after result"}, reads - r0, exp_reads);
        chk(res_seen == s0 + 1, "R9 single result", res_seen - s0, 1);
        chk(fl_ce_n && fl_we_n && fl_oe_n, {tag, " bus idle"}, {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dout_en, "R1 pins in reset",
            {fl_ce_n, fl_we_n, fl_oe_n, fl_dout_en}, 4'b1110);
        chk(!done && !err, "R1 results in reset", {done, err}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(fl_ce_n && fl_we_n && fl_oe_n && !fl_dout_en && !done && !err, "R1 idle after reset",
            {fl_ce_n, fl_we_n, fl_oe_n, fl_dout_en, done, err}, 6'b111000);

        // R2 R5 R6: several busy polls, then flip, then blank confirm
        run_erase(AW'('h32000), 5, 8'hFF, RES_DONE, 7, 0, "R5");
        // R6: status already high on first poll
        run_erase(AW'('h01234), 0, 8'hFF, RES_DONE, 2, 0, "R6");
        // R7: confirming read not blank
        run_erase(AW'('h5F0F0), 3, 8'hF7, RES_ERR, 5, 0, "R7");
        // R8: poll budget exhausted
        run_erase(AW'('h7FFFF), 20, 8'hFF, RES_ERR, MAXP, 0, "R8");
        // R8 boundary: flip on the last allowed poll still succeeds
        run_erase(AW'('h10000), MAXP - 1, 8'hFF, RES_DONE, MAXP + 1, 0, "R8 edge");
        // R9: second request during the command phase is ignored
        run_erase(AW'('h2A5A5), 4, 8'hFF, RES_DONE, 6, 1, "R9");
        // R10: back-to-back requests after done
        run_erase(AW'('h00000), 2, 8'hFF, RES_DONE, 4, 0, "R10");
        run_erase(AW'('h4C000), 1, 8'hFF, RES_DONE, 3, 0, "R10");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule